// File: doc/BRIEF.md
# Dual Trigger Event Monitor with Time Stamp

This block watches two asynchronous external trigger lines. For each line it reports the current level and a sticky event flag. The event flag is raised whenever the level changes, in either direction. The block also runs a free-running counter, which is its time base. The same count is driven out on `time_now`, so the frame-stamping logic elsewhere on the chip uses exactly the same clock source. When an event arrives and no earlier event is still unacknowledged, the current count is latched as the event time stamp.

Software reaches the block through a small register read port. A status read returns both level bits and both event flags in a single word. That read also acts as the acknowledge and clears the event flags. Two other addresses return the latched time stamp and the live time base.

Top module: `trig_event_monitor`

## Requirements
- R1: After reset, `rd_data` and `time_now` are zero, and a status read returns zero while both triggers are low.
- R2: `time_now` starts at zero after reset and rises by exactly one on every clock cycle.
- R3: Each trigger passes through a two-flop synchronizer. The synchronized level of trigger 0 appears at status bit 5, and trigger 1 at status bit 6. A change at the input is first visible in a status read issued two cycles after the cycle in which the input was sampled.
- R4: Any rising or falling edge of a synchronized trigger sets that trigger's event flag. Trigger 0's flag is status bit 1 and trigger 1's flag is status bit 2.
- R5: A read of address 0 (status) returns the word as it stood before the read, and then clears both event flags.
- R6: If an edge is detected in the same cycle as a status read, the edge wins and its event flag stays set after the read.
- R7: The stamp register (address 1) loads the time base value on an edge that arrives while no event flag is held, or that coincides with a status read. It keeps that value through later edges until a status read.
- R8: Status bits 0, 3, 4 and 7 and upward read as zero. Address 2 returns the time base, address 3 returns zero, and reads of addresses 1 to 3 leave the event flags unchanged.
- R9: `rd_data` is registered. It takes the selected value on the clock edge where `rd_en` is high, and it holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic and for the time base |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 2 | Asynchronous trigger lines, bit 0 is trigger 0 |
| rd_en | input | 1 | Read strobe; a read of address 0 also acknowledges events |
| rd_addr | input | 2 | 0 status, 1 stamp, 2 time base, 3 reserved |
| rd_data | output | TS_W | Registered read data |
| time_now | output | TS_W | Live time base shared with frame stamping |

## Verification
A corrupted event flag stays hidden until the next status read. It then shows up in bit 1 or bit 2 one cycle after that read's strobe, and it shows again on the read after that if the clear misbehaved. A wrong stamp appears only when address 1 is read, so the bench reads the stamp after every event pattern. Synchronizer depth mistakes shift the level bits by a cycle. The bench makes this visible by sweeping the gap between a trigger toggle and a status read. A time base fault is visible on `time_now` in the very next cycle.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;

  localparam int NUM_TRIG = 2;
  localparam int STAT_W   = 8;
  localparam int PEND_LSB = 1;
  localparam int LVL_LSB  = 5;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_STAMP  = 2'd1,
    ADDR_NOW    = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;

  // Sticky flags: a new edge wins over the acknowledge.
  function automatic logic [NUM_TRIG-1:0] pend_next(
    input logic [NUM_TRIG-1:0] pend,
    input logic [NUM_TRIG-1:0] edges,
    input logic                clr
  );
    return edges | (pend & ~{NUM_TRIG{clr}});
  endfunction

  // Stamp loads on the first event of an unacknowledged group.
  function automatic logic stamp_load(
    input logic [NUM_TRIG-1:0] pend,
    input logic [NUM_TRIG-1:0] edges,
    input logic                clr
  );
    return (|edges) && ((pend == '0) || clr);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
    input logic [NUM_TRIG-1:0] pend,
    input logic [NUM_TRIG-1:0] lvl
  );
    logic [STAT_W-1:0] w;
    w = '0;
    w[PEND_LSB +: NUM_TRIG] = pend;
    w[LVL_LSB  +: NUM_TRIG] = lvl;
    return w;
  endfunction

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign edge_o  = level_o ^ prev_q;
endmodule

// File: rtl/trig_time_base.sv
module trig_time_base #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign now_o = cnt_q;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/trig_event_regs.sv
module trig_event_regs
  import trig_cap_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] edges_i,
  input  logic                clr_i,
  input  logic [TS_W-1:0]     now_i,
  output logic [NUM_TRIG-1:0] pend_o,
  output logic [TS_W-1:0]     stamp_o
);
  logic [NUM_TRIG-1:0] pend_q;
  logic [TS_W-1:0]     stamp_q;
  logic                load_w;

  assign load_w = stamp_load(pend_q, edges_i, clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      stamp_q <= '0;
    end else begin
      pend_q <= pend_next(pend_q, edges_i, clr_i);
      if (load_w) stamp_q <= now_i;
    end
  end

  assign pend_o  = pend_q;
  assign stamp_o = stamp_q;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_chk
    a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      edges_i[i] |=> pend_q[i]);
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_i[i] && clr_i) |=> pend_q[i]);
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !edges_i[i]) |=> !pend_q[i]);
  end

  a_r7_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pend_q) && !clr_i) |=> $stable(stamp_q));
  a_r7_stamp_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((|edges_i) && (pend_q == '0)) |=> stamp_q == $past(now_i));
endmodule

// File: rtl/trig_event_monitor.sv
module trig_event_monitor
  import trig_cap_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                rd_en,
  input  logic [1:0]          rd_addr,
  output logic [TS_W-1:0]     rd_data,
  output logic [TS_W-1:0]     time_now
);
  localparam int PAD_W = TS_W - STAT_W;

  logic [NUM_TRIG-1:0] lvl_w;
  logic [NUM_TRIG-1:0] edge_w;
  logic [NUM_TRIG-1:0] pend_w;
  logic [TS_W-1:0]     stamp_w;
  logic [STAT_W-1:0]   status_w;
  logic                ack_w;
  logic [TS_W-1:0]     sel_w;
  logic [TS_W-1:0]     rd_q;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_sync
    trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(trig_in[i]),
      .level_o (lvl_w[i]),
      .edge_o  (edge_w[i])
    );
  end

  trig_time_base #(.W(TS_W)) u_time (
    .clk  (clk),
    .rst_n(rst_n),
    .now_o(time_now)
  );

  assign ack_w = rd_en && (reg_addr_e'(rd_addr) == ADDR_STATUS);

  trig_event_regs #(.TS_W(TS_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .edges_i(edge_w),
    .clr_i  (ack_w),
    .now_i  (time_now),
    .pend_o (pend_w),
    .stamp_o(stamp_w)
  );

  assign status_w = pack_status(pend_w, lvl_w);

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      ADDR_STATUS: sel_w = {{PAD_W{1'b0}}, status_w};
      ADDR_STAMP:  sel_w = stamp_w;
      ADDR_NOW:    sel_w = time_now;
      default:     sel_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= sel_w;
  end

  assign rd_data = rd_q;

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd3) |=> rd_data == '0);
  a_r8_no_side_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != 2'd0 && edge_w == '0) |=> pend_w == $past(pend_w));
endmodule

// File: tb/trig_event_monitor_tb_top.sv
module trig_event_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  trig_in;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic [31:0] time_now;

  always #5 clk = ~clk;

  trig_event_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .time_now(time_now)
  );

  int    n_checks = 0;
  int    n_err    = 0;
  string cur_req  = "R1";

  // Behavioural model state
  bit [1:0]  m_s1, m_s2, m_old, m_flag;
  bit [31:0] m_stamp, m_clock, m_rd;

  function automatic bit [31:0] status_of(bit [1:0] f, bit [1:0] l);
    bit [31:0] s = 0;
    s[1] = f[0]; s[2] = f[1]; s[5] = l[0]; s[6] = l[1];
    return s;
  endfunction

  task automatic chk(input string req, input string what,
                     input bit [31:0] act, input bit [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_old = 0; m_flag = 0;
    m_stamp = 0; m_clock = 0; m_rd = 0;
  endtask

  task automatic model_step(input bit [1:0] t, input bit re, input bit [1:0] a);
    bit [1:0] chg = m_s2 ^ m_old;
    bit       ack = re && (a == 0);
    bit       first = (chg != 0) && (m_flag == 0 || ack);
    if (re) begin
      if (a == 0)      m_rd = status_of(m_flag, m_s2);
      else if (a == 1) m_rd = m_stamp;
      else if (a == 2) m_rd = m_clock;
      else             m_rd = 0;
    end
    if (first) m_stamp = m_clock;
    m_flag  = chg | (ack ? 2'b00 : m_flag);
    m_clock = m_clock + 1;
    m_old   = m_s2;
    m_s2    = m_s1;
    m_s1    = t;
  endtask

  task automatic tick(input bit [1:0] t, input bit re, input bit [1:0] a);
    trig_in = t; rd_en = re; rd_addr = a;
    @(posedge clk);
    model_step(t, re, a);
    @(negedge clk);
    chk(cur_req, "rd_data", rd_data, m_rd);
    chk("R2", "time_now", time_now, m_clock);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog R1..R9 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    bit [1:0] t;
    rst_n = 1'b0; trig_in = 0; rd_en = 0; rd_addr = 0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "rd_data after reset", rd_data, 32'h0);
    chk("R1", "time_now after reset", time_now, 32'h0);
    cur_req = "R1";
    tick(2'b00, 1, 0);
    chk("R1", "idle status", rd_data, 32'h0);

    // Level and flag of trigger 0
    cur_req = "R3";
    tick(2'b01, 0, 0);
    repeat (4) tick(2'b01, 0, 0);
    cur_req = "R5";
    tick(2'b01, 1, 0);
    chk("R5", "status before clear", rd_data, 32'h22);
    tick(2'b01, 1, 0);
    chk("R5", "status after clear", rd_data, 32'h20);

    // Stamp on first event, held across a second one
    cur_req = "R7";
    tick(2'b11, 0, 0);
    repeat (3) tick(2'b11, 0, 0);
    tick(2'b10, 0, 0);
    repeat (3) tick(2'b10, 0, 0);
    tick(2'b10, 1, 1);
    cur_req = "R4";
    tick(2'b10, 1, 0);
    chk("R4", "both flags and trigger1 level", rd_data, 32'h46);
    cur_req = "R7";
    tick(2'b10, 1, 1);

    // Other addresses do not clear
    cur_req = "R8";
    tick(2'b00, 0, 0);
    repeat (4) tick(2'b00, 0, 0);
    tick(2'b00, 1, 3);
    chk("R8", "reserved address", rd_data, 32'h0);
    tick(2'b00, 1, 2);
    tick(2'b00, 1, 1);
    tick(2'b00, 1, 0);
    tick(2'b00, 1, 0);

    // Sweep the gap between toggle and acknowledge (edge-wins cases)
    cur_req = "R6";
    t = 2'b00;
    for (int gap = 0; gap < 6; gap++) begin
      t = ~t;
      tick(t, gap == 0, 0);
      for (int k = 1; k <= gap; k++) tick(t, k == gap, 0);
      repeat (3) tick(t, 0, 0);
      tick(t, 1, 0);
      tick(t, 1, 1);
      tick(t, 1, 0);
    end

    // Random traffic with per-cycle comparison
    cur_req = "R9";
    for (int n = 0; n < 3000; n++) begin
      bit [31:0] r = $urandom;
      if (r[3:0] == 0) t[0] = ~t[0];
      if (r[7:4] == 0) t[1] = ~t[1];
      tick(t, r[10:8] == 0, r[12:11]);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule